// File: doc/BRIEF.md
# Search-Cache Maintenance Command Engine

The engine accepts a seven-word, 32-bit command and carries out maintenance and statistics work on a small cache of search results. The cache is kept twice, once for a flow search engine and once for an address search engine, and a select bit in the command picks which copy the command works on. Each cache set holds one entry with a valid bit, a dirty bit, a tag (the table index of the cached result), a 32-bit result word and a saturating hit counter. A backing table, addressed by engine and tag, is held inside the block. Write-backs copy dirty entries into this table, and any report can read it.

A single-entry command acts on the set named in the command and finishes in one cycle. A whole-cache command walks every set of the selected engine, one set per clock, and reports once when the walk ends. Every command returns a status record on one of two status channels. The record echoes the command's 64-bit metadata and opcode and adds an error flag, the target entry's state, the backing-table word at that entry's tag, and the number of entries written back. A lookup-side port installs entries in the cache (fill) and counts hits on them (touch). This port is ignored while a command is running.

Top module: `gsc_engine`

## Requirements
- R1: After reset, busy is 0, both status strobes are 0 and every cache entry is invalid, clean, with tag 0 and hit count 0.
- R2: Command layout. Word 0 bits 19:0 are the table index. Word 1 holds the opcode in bits 11:8, the engine select in bit 12 (0 = flow, 1 = address), the status channel in bit 13, the byte-swap enable in bit 14, the index-mode enable in bit 15 and the set number in bits 19:16. Words 2 (low half) and 3 (high half) are the metadata. Each command produces exactly one status: a one-cycle strobe on st_vld[channel] that carries the metadata and opcode unchanged.
- R3: Opcode 0 reports the target set's valid bit, dirty bit and hit count, the target flag, and the backing-table word at that entry's tag. It changes nothing.
- R4: With index mode on, the entry is the target only if it is valid and its tag equals the whole 20-bit index. With index mode off, any valid entry in the set is the target. Single-entry actions change only a target entry.
- R5: Opcode 2 writes a dirty target to the table at {engine, tag}, clears its dirty bit and reports a count of 1. A clean target, or a miss, reports 0 and changes nothing. Single-entry opcodes 0, 2, 4, 6 and 8 report the entry state as it was before the action.
- R6: When byte swap is on, the word written back has its four bytes in reverse order. When it is off, the word is written unchanged.
- R7: Opcode 4 clears the target's valid bit without writing to the table. Opcode 6 writes back (as in R5) and then invalidates.
- R8: Opcode 8 sets the target's hit count to 0 and reports the count it had before.
- R9: Opcodes 3, 5 and 7 act on every valid entry of the selected engine, each with the action of opcode 2, 4 or 6 respectively. Busy stays high for exactly SETS cycles. The status reports the number of entries written back, with target and entry fields 0.
- R10: A command never changes the cache entries or the table words of the engine it does not select.
- R11: Opcodes 9 to 15 report the error flag with every other report field 0 and change nothing.
- R12: Opcode 1 reports with every report field 0 and changes nothing.
- R13: A single-entry command holds busy for one cycle. While busy is high, a new command, a fill and a touch are all ignored.
- R14: A fill installs a valid entry with the given tag, data and dirty bit and a hit count of 0. A touch adds 1 to the hit count of a valid entry and stops at the maximum value. A touch on an invalid entry has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present; taken when busy is low |
| cmd_data | input | 224 | Seven command words, word k at bits 32k+31:32k |
| busy | output | 1 | A command is running |
| fill_en | input | 1 | Install an entry |
| fill_eng | input | 1 | Engine of the fill |
| fill_set | input | 4 | Set of the fill |
| fill_tag | input | 20 | Table index of the filled result |
| fill_data | input | 32 | Result word of the fill |
| fill_dirty | input | 1 | Fill arrives modified |
| touch_en | input | 1 | Count one hit |
| touch_eng | input | 1 | Engine of the hit |
| touch_set | input | 4 | Set of the hit |
| st_vld | output | 2 | Status strobe, one bit per channel |
| st_meta | output | 64 | Echoed metadata |
| st_op | output | 4 | Echoed opcode |
| st_err | output | 1 | Reserved opcode |
| st_hit | output | 1 | Entry was the target |
| st_ent_valid | output | 1 | Entry valid bit before the action |
| st_ent_dirty | output | 1 | Entry dirty bit before the action |
| st_hits | output | 8 | Entry hit count before the action |
| st_tbl | output | 32 | Backing-table word at the entry's tag, before the action |
| st_wbcnt | output | 5 | Entries written back |

## Verification
Single-entry opcodes are driven against a dirty hit, a clean hit, a tag miss in index mode and the same set with index mode off. This shows that the target test is separate from the action chosen. Write-backs are done with and without byte swap and then read back through opcode 0, so a swapped word cannot be mistaken for a plain one. Whole-cache walks run over a mix of dirty, clean and empty sets, with a command and a fill injected during the walk. The report count and the later reads then expose any wrong walk length, any double count, or any intrusion accepted while busy. The same tag is used on both engines so that a leak from one engine into the other shows up.

// File: rtl/gsc_pkg.sv
package gsc_pkg;

  typedef struct packed {
    logic [3:0]  op;
    logic        eng;
    logic        chan;
    logic        swp;
    logic        idx;
    logic [3:0]  set;
    logic [19:0] index;
    logic [63:0] meta;
  } cmd_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ONE, ST_ALL} state_e;

  function automatic cmd_t gsc_decode(input logic [223:0] w);
    cmd_t c;
    c.index = w[19:0];
    c.op    = w[43:40];
    c.eng   = w[44];
    c.chan  = w[45];
    c.swp   = w[46];
    c.idx   = w[47];
    c.set   = w[51:48];
    c.meta  = {w[127:96], w[95:64]};
    return c;
  endfunction

  function automatic logic [31:0] byte_rev(input logic [31:0] d);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = d[8*(3-i) +: 8];
    return r;
  endfunction

  function automatic logic op_whole(input logic [3:0] op);
    return (op == 4'd3) || (op == 4'd5) || (op == 4'd7);
  endfunction

  function automatic logic op_wb(input logic [3:0] op);
    return (op == 4'd2) || (op == 4'd3) || (op == 4'd6) || (op == 4'd7);
  endfunction

  function automatic logic op_inv(input logic [3:0] op);
    return (op == 4'd4) || (op == 4'd5) || (op == 4'd6) || (op == 4'd7);
  endfunction

  function automatic logic op_report(input logic [3:0] op);
    return (op == 4'd0) || (op == 4'd2) || (op == 4'd4) || (op == 4'd6) || (op == 4'd8);
  endfunction

  function automatic logic op_rsv(input logic [3:0] op);
    return op > 4'd8;
  endfunction

endpackage

// File: rtl/gsc_table.sv
module gsc_table #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 32,
  localparam int DEPTH = 2 ** ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  assign rd_data = mem_q[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end
endmodule

// File: rtl/gsc_store.sv
module gsc_store #(
  parameter int SETS  = 16,
  parameter int TAG_W = 8,
  parameter int HIT_W = 8,
  localparam int SW = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             fill_en,
  input  logic             fill_eng,
  input  logic [SW-1:0]    fill_set,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [31:0]      fill_data,
  input  logic             fill_dirty,
  input  logic             touch_en,
  input  logic             touch_eng,
  input  logic [SW-1:0]    touch_set,
  input  logic             rd_eng,
  input  logic [SW-1:0]    rd_set,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  output logic [HIT_W-1:0] rd_hits,
  output logic [31:0]      rd_data,
  input  logic             wr_en,
  input  logic             wr_eng,
  input  logic [SW-1:0]    wr_set,
  input  logic             wr_valid,
  input  logic             wr_dirty,
  input  logic [HIT_W-1:0] wr_hits
);
  localparam logic [HIT_W-1:0] HMAX = '1;

  logic             v_q [2][SETS];
  logic             d_q [2][SETS];
  logic [TAG_W-1:0] t_q [2][SETS];
  logic [HIT_W-1:0] h_q [2][SETS];
  logic [31:0]      x_q [2][SETS];

  assign rd_valid = v_q[rd_eng][rd_set];
  assign rd_dirty = d_q[rd_eng][rd_set];
  assign rd_tag   = t_q[rd_eng][rd_set];
  assign rd_hits  = h_q[rd_eng][rd_set];
  assign rd_data  = x_q[rd_eng][rd_set];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < 2; e++) begin
        for (int s = 0; s < SETS; s++) begin
          v_q[e][s] <= 1'b0;
          d_q[e][s] <= 1'b0;
          t_q[e][s] <= '0;
          h_q[e][s] <= '0;
          x_q[e][s] <= '0;
        end
      end
    end else if (wr_en) begin
      v_q[wr_eng][wr_set] <= wr_valid;
      d_q[wr_eng][wr_set] <= wr_dirty;
      h_q[wr_eng][wr_set] <= wr_hits;
    end else if (!busy) begin
      if (touch_en && v_q[touch_eng][touch_set] && (h_q[touch_eng][touch_set] != HMAX))
        h_q[touch_eng][touch_set] <= h_q[touch_eng][touch_set] + 1'b1;
      if (fill_en) begin
        v_q[fill_eng][fill_set] <= 1'b1;
        d_q[fill_eng][fill_set] <= fill_dirty;
        t_q[fill_eng][fill_set] <= fill_tag;
        h_q[fill_eng][fill_set] <= '0;
        x_q[fill_eng][fill_set] <= fill_data;
      end
    end
  end
endmodule

// File: rtl/gsc_engine.sv
module gsc_engine
  import gsc_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int HIT_W = 8,
  parameter int IDX_W = 20,
  parameter int TAG_W = 8,
  localparam int SW = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [223:0]     cmd_data,
  output logic             busy,
  input  logic             fill_en,
  input  logic             fill_eng,
  input  logic [SW-1:0]    fill_set,
  input  logic [IDX_W-1:0] fill_tag,
  input  logic [31:0]      fill_data,
  input  logic             fill_dirty,
  input  logic             touch_en,
  input  logic             touch_eng,
  input  logic [SW-1:0]    touch_set,
  output logic [1:0]       st_vld,
  output logic [63:0]      st_meta,
  output logic [3:0]       st_op,
  output logic             st_err,
  output logic             st_hit,
  output logic             st_ent_valid,
  output logic             st_ent_dirty,
  output logic [HIT_W-1:0] st_hits,
  output logic [31:0]      st_tbl,
  output logic [SW:0]      st_wbcnt
);
  state_e        state;
  cmd_t          cq, cin;
  logic [SW-1:0] walk, cur_set;
  logic [SW:0]   wbcnt;

  logic             rd_valid, rd_dirty;
  logic [TAG_W-1:0] rd_tag;
  logic [HIT_W-1:0] rd_hits;
  logic [31:0]      rd_data, tbl_rd;

  // named internal events
  logic accept, single, whole, last, done, tgt, act_ok, wb_fire, inv_fire, clr_fire, rep;

  logic unused_bits;
  assign unused_bits = ^{cmd_data[223:128], cmd_data[63:52], cmd_data[31:20], fill_tag[IDX_W-1:TAG_W]};

  assign cin     = gsc_decode(cmd_data);
  assign busy    = (state != ST_IDLE);
  assign accept  = cmd_valid && !busy;
  assign single  = (state == ST_ONE);
  assign whole   = (state == ST_ALL);
  assign last    = (walk == SW'(SETS - 1));
  assign done    = single || (whole && last);
  assign cur_set = whole ? walk : cq.set[SW-1:0];

  assign tgt      = rd_valid && (!cq.idx || (cq.index == IDX_W'(rd_tag)));
  assign act_ok   = whole ? rd_valid : (single && tgt);
  assign wb_fire  = act_ok && op_wb(cq.op) && rd_dirty;
  assign inv_fire = act_ok && op_inv(cq.op);
  assign clr_fire = single && tgt && (cq.op == 4'd8);
  assign rep      = single && op_report(cq.op);

  gsc_store #(.SETS(SETS), .TAG_W(TAG_W), .HIT_W(HIT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .fill_en(fill_en), .fill_eng(fill_eng), .fill_set(fill_set),
    .fill_tag(fill_tag[TAG_W-1:0]), .fill_data(fill_data), .fill_dirty(fill_dirty),
    .touch_en(touch_en), .touch_eng(touch_eng), .touch_set(touch_set),
    .rd_eng(cq.eng), .rd_set(cur_set),
    .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag), .rd_hits(rd_hits), .rd_data(rd_data),
    .wr_en(wb_fire || inv_fire || clr_fire), .wr_eng(cq.eng), .wr_set(cur_set),
    .wr_valid(rd_valid && !inv_fire), .wr_dirty(rd_dirty && !wb_fire),
    .wr_hits(clr_fire ? '0 : rd_hits)
  );

  gsc_table #(.ADDR_W(TAG_W + 1), .DATA_W(32)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_addr({cq.eng, rd_tag}), .rd_data(tbl_rd),
    .wr_en(wb_fire), .wr_addr({cq.eng, rd_tag}),
    .wr_data(cq.swp ? byte_rev(rd_data) : rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      cq           <= '0;
      walk         <= '0;
      wbcnt        <= '0;
      st_vld       <= '0;
      st_meta      <= '0;
      st_op        <= '0;
      st_err       <= 1'b0;
      st_hit       <= 1'b0;
      st_ent_valid <= 1'b0;
      st_ent_dirty <= 1'b0;
      st_hits      <= '0;
      st_tbl       <= '0;
      st_wbcnt     <= '0;
    end else begin
      st_vld <= '0;
      case (state)
        ST_IDLE: if (accept) begin
          cq    <= cin;
          walk  <= '0;
          wbcnt <= '0;
          state <= op_whole(cin.op) ? ST_ALL : ST_ONE;
        end
        ST_ONE:  state <= ST_IDLE;
        ST_ALL: begin
          walk  <= walk + 1'b1;
          wbcnt <= wbcnt + (SW+1)'(wb_fire);
          if (last) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
      if (done) begin
        st_vld       <= cq.chan ? 2'b10 : 2'b01;
        st_meta      <= cq.meta;
        st_op        <= cq.op;
        st_err       <= single && op_rsv(cq.op);
        st_hit       <= rep && tgt;
        st_ent_valid <= rep && rd_valid;
        st_ent_dirty <= rep && rd_dirty;
        st_hits      <= rep ? rd_hits : '0;
        st_tbl       <= rep ? tbl_rd : '0;
        st_wbcnt     <= wbcnt + (SW+1)'(wb_fire);
      end
    end
  end
endmodule

// File: rtl/gsc_chk.sv
module gsc_chk #(
  parameter int SW = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        accept,
  input logic [1:0]  st_vld,
  input logic        st_err,
  input logic [SW:0] st_wbcnt,
  input logic        wb_fire,
  input logic        inv_fire,
  input logic [3:0]  op_q
);
  a_r2_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(st_vld));

  a_r13_accept_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  a_r13_status_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (|st_vld) |-> !busy);

  a_r9_busy_end_reports: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (|st_vld));

  a_r11_error_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    ((|st_vld) && st_err) |-> (st_wbcnt == '0));

  a_r11_reserved_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (op_q > 4'd8)) |-> (!wb_fire && !inv_fire));

  a_r5_writeback_in_command: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_fire || inv_fire) |-> busy);
endmodule

bind gsc_engine gsc_chk #(.SW(SW)) u_gsc_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .accept(accept),
  .st_vld(st_vld), .st_err(st_err), .st_wbcnt(st_wbcnt),
  .wb_fire(wb_fire), .inv_fire(inv_fire), .op_q(cq.op)
);

// File: tb/test_gsc_engine.sv
module test_gsc_engine;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [223:0] cmd_data = '0;
  logic         busy;
  logic         fill_en = 1'b0, fill_eng = 1'b0, fill_dirty = 1'b0;
  logic [3:0]   fill_set = '0;
  logic [19:0]  fill_tag = '0;
  logic [31:0]  fill_data = '0;
  logic         touch_en = 1'b0, touch_eng = 1'b0;
  logic [3:0]   touch_set = '0;
  logic [1:0]   st_vld;
  logic [63:0]  st_meta;
  logic [3:0]   st_op;
  logic         st_err, st_hit, st_ent_valid, st_ent_dirty;
  logic [7:0]   st_hits;
  logic [31:0]  st_tbl;
  logic [4:0]   st_wbcnt;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  gsc_engine i_gsc_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data), .busy(busy),
    .fill_en(fill_en), .fill_eng(fill_eng), .fill_set(fill_set), .fill_tag(fill_tag),
    .fill_data(fill_data), .fill_dirty(fill_dirty),
    .touch_en(touch_en), .touch_eng(touch_eng), .touch_set(touch_set),
    .st_vld(st_vld), .st_meta(st_meta), .st_op(st_op), .st_err(st_err), .st_hit(st_hit),
    .st_ent_valid(st_ent_valid), .st_ent_dirty(st_ent_dirty), .st_hits(st_hits),
    .st_tbl(st_tbl), .st_wbcnt(st_wbcnt)
  );

  // reference model
  bit          m_v [2][16];
  bit          m_d [2][16];
  logic [19:0] m_t [2][16];
  int          m_h [2][16];
  logic [31:0] m_x [2][16];
  logic [31:0] m_tbl [2][256];

  typedef struct {
    logic [1:0]  vld;
    logic [63:0] meta;
    logic [3:0]  op;
    logic        err, hit, ev, ed;
    logic [7:0]  hits;
    logic [31:0] tbl;
    logic [4:0]  cnt;
    string       req;
  } exp_t;
  exp_t q[$];

  function automatic logic [31:0] swap4(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  task automatic check(input bit ok, input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && st_vld != 2'b00) begin
      if (q.size() == 0) begin
        check(1'b0, "R13", "unexpected status", {62'd0, st_vld}, 64'd0);
      end else begin
        exp_t e;
        logic [127:0] a, x;
        e = q.pop_front();
        a = {st_vld, st_op, st_err, st_hit, st_ent_valid, st_ent_dirty, st_hits, st_wbcnt, st_tbl, st_meta[31:0], 1'b0, st_meta[63:32]};
        x = {e.vld, e.op, e.err, e.hit, e.ev, e.ed, e.hits, e.cnt, e.tbl, e.meta[31:0], 1'b0, e.meta[63:32]};
        total++;
        if (a !== x) begin
          bad++;
          $display("FAIL %s status actual=%h expected=%h", e.req, a, x);
        end
      end
    end
  end

  task automatic fill(input bit eng, input int set, input logic [19:0] tag, input logic [31:0] data, input bit dirty);
    while (busy) @(negedge clk);
    fill_en = 1'b1; fill_eng = eng; fill_set = 4'(set); fill_tag = tag; fill_data = data; fill_dirty = dirty;
    @(negedge clk);
    fill_en = 1'b0;
    m_v[eng][set] = 1; m_d[eng][set] = dirty; m_t[eng][set] = tag; m_h[eng][set] = 0; m_x[eng][set] = data;
  endtask

  task automatic touch(input bit eng, input int set, input int n);
    while (busy) @(negedge clk);
    touch_en = 1'b1; touch_eng = eng; touch_set = 4'(set);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (m_v[eng][set] && m_h[eng][set] < 255) m_h[eng][set]++;
    end
    touch_en = 1'b0;
  endtask

  task automatic send(input int op, input bit eng, input bit chan, input bit swp, input bit idx,
                      input int set, input logic [19:0] index, input logic [63:0] meta,
                      input string req, input bit intrude);
    exp_t e;
    logic [223:0] w;
    int n, cnt, want;
    bit tg;
    w = '0;
    w[19:0] = index; w[31:20] = 12'hA5C;
    w[43:40] = 4'(op); w[44] = eng; w[45] = chan; w[46] = swp; w[47] = idx; w[51:48] = 4'(set);
    w[95:64] = meta[31:0]; w[127:96] = meta[63:32]; w[223:200] = 24'h5A5A5A;
    e.vld = chan ? 2'b10 : 2'b01; e.meta = meta; e.op = 4'(op); e.req = req;
    e.err = 0; e.hit = 0; e.ev = 0; e.ed = 0; e.hits = 0; e.tbl = 0; e.cnt = 0;
    if (op >= 9) begin
      e.err = 1;
    end else if (op == 3 || op == 5 || op == 7) begin
      cnt = 0;
      for (int s = 0; s < 16; s++) begin
        if (m_v[eng][s]) begin
          if (op != 5 && m_d[eng][s]) begin
            m_tbl[eng][m_t[eng][s][7:0]] = swp ? swap4(m_x[eng][s]) : m_x[eng][s];
            m_d[eng][s] = 0;
            cnt++;
          end
          if (op != 3) m_v[eng][s] = 0;
        end
      end
      e.cnt = 5'(cnt);
    end else if (op != 1) begin
      tg = m_v[eng][set] && (!idx || m_t[eng][set] == index);
      e.hit = tg; e.ev = m_v[eng][set]; e.ed = m_d[eng][set];
      e.hits = 8'(m_h[eng][set]); e.tbl = m_tbl[eng][m_t[eng][set][7:0]];
      if (tg) begin
        if ((op == 2 || op == 6) && m_d[eng][set]) begin
          m_tbl[eng][m_t[eng][set][7:0]] = swp ? swap4(m_x[eng][set]) : m_x[eng][set];
          m_d[eng][set] = 0;
          e.cnt = 1;
        end
        if (op == 4 || op == 6) m_v[eng][set] = 0;
        if (op == 8) m_h[eng][set] = 0;
      end
    end
    q.push_back(e);
    while (busy) @(negedge clk);
    cmd_valid = 1'b1; cmd_data = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (busy) begin
      n++;
      if (intrude && n <= 3) begin
        cmd_valid = 1'b1; cmd_data = '0; cmd_data[43:40] = 4'd8; cmd_data[45] = 1'b1;
        fill_en = 1'b1; fill_eng = 1'b0; fill_set = 4'd3; fill_tag = 20'h77; fill_data = 32'hDEAD0003; fill_dirty = 1'b1;
      end else begin
        cmd_valid = 1'b0; fill_en = 1'b0;
      end
      @(negedge clk);
      if (n > 100) break;
    end
    cmd_valid = 1'b0; fill_en = 1'b0;
    want = (op == 3 || op == 5 || op == 7) ? 16 : 1;
    check(n == want, (want == 16) ? "R9" : "R13", "busy cycles", 64'(n), 64'(want));
  endtask

  initial begin
    #(20ns * 150000);
    check(1'b0, "R13", "watchdog expired", 64'd0, 64'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int e = 0; e < 2; e++) begin
      for (int s = 0; s < 16; s++) begin
        m_v[e][s] = 0; m_d[e][s] = 0; m_t[e][s] = '0; m_h[e][s] = 0; m_x[e][s] = '0;
      end
      for (int i = 0; i < 256; i++) m_tbl[e][i] = '0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1", "busy after reset", {63'd0, busy}, 64'd0);
    check(st_vld == 2'b00, "R1", "status after reset", {62'd0, st_vld}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && st_vld == 2'b00, "R1", "idle after release", {62'd0, st_vld}, 64'd0);
    send(0, 1, 0, 0, 0, 6, 20'h0, 64'h0101_0000_0000_0001, "R1", 0);

    // R14 fill/touch, R3 read stats, R2 metadata and channel
    fill(0, 2, 20'h11, 32'h1122_3344, 1);
    touch(0, 2, 3);
    send(0, 0, 0, 0, 1, 2, 20'h11, 64'hFEDC_BA98_7654_3210, "R3", 0);
    send(0, 0, 1, 0, 1, 2, 20'h11, 64'h0123_4567_89AB_CDEF, "R2", 0);
    // R4 index miss (tag differs, also upper index bits)
    send(0, 0, 0, 0, 1, 2, 20'h12, 64'h2, "R4", 0);
    send(2, 0, 0, 0, 1, 2, 20'h10011, 64'h3, "R4", 0);
    send(0, 0, 1, 0, 0, 2, 20'h99, 64'h4, "R4", 0);
    // R5/R6 write-back with swap, then read back
    send(2, 0, 0, 1, 0, 2, 20'h0, 64'h5, "R6", 0);
    send(0, 0, 0, 0, 0, 2, 20'h0, 64'h6, "R6", 0);
    send(2, 0, 1, 0, 0, 2, 20'h0, 64'h7, "R5", 0);
    // R10 other engine, same tag
    fill(1, 2, 20'h11, 32'hCAFE_F00D, 1);
    touch(1, 2, 2);
    // R8 clear stats
    send(8, 0, 0, 0, 1, 2, 20'h11, 64'h8, "R8", 0);
    send(0, 0, 0, 0, 0, 2, 20'h0, 64'h9, "R8", 0);
    // R7 write-back and invalidate on engine 1
    send(6, 1, 1, 0, 1, 2, 20'h11, 64'hA, "R7", 0);
    send(0, 1, 0, 0, 0, 2, 20'h0, 64'hB, "R7", 0);
    send(0, 0, 0, 0, 0, 2, 20'h0, 64'hC, "R10", 0);
    // R7 invalidate does not copy
    fill(0, 2, 20'h11, 32'h5566_7788, 1);
    send(4, 0, 0, 0, 0, 2, 20'h0, 64'hD, "R7", 0);
    send(0, 0, 1, 0, 0, 2, 20'h0, 64'hE, "R7", 0);
    // R11 reserved codes
    fill(0, 4, 20'h21, 32'hAAAA_5555, 1);
    send(9, 0, 0, 0, 0, 4, 20'h0, 64'hF, "R11", 0);
    send(15, 0, 1, 1, 1, 4, 20'h21, 64'h10, "R11", 0);
    send(0, 0, 0, 0, 0, 4, 20'h0, 64'h11, "R11", 0);
    // R12 search disable
    send(1, 0, 1, 0, 0, 4, 20'h21, 64'h12, "R12", 0);
    send(0, 0, 0, 0, 0, 4, 20'h0, 64'h13, "R12", 0);
    // R9 whole-cache walks, R13 intrusion while busy
    fill(0, 0, 20'h30, 32'h0000_0030, 1);
    fill(0, 5, 20'h35, 32'h0102_0305, 1);
    fill(0, 15, 20'h3F, 32'hF0F1_F2F3, 1);
    fill(0, 7, 20'h37, 32'h0000_0037, 0);
    send(3, 0, 1, 1, 0, 0, 20'h0, 64'h14, "R9", 1);
    send(0, 0, 0, 0, 0, 3, 20'h0, 64'h15, "R13", 0);
    send(0, 0, 0, 0, 0, 15, 20'h0, 64'h16, "R9", 0);
    send(7, 0, 0, 0, 0, 0, 20'h0, 64'h17, "R9", 0);
    send(0, 0, 1, 0, 0, 5, 20'h0, 64'h18, "R9", 0);
    fill(1, 1, 20'h41, 32'h4141_4141, 1);
    fill(1, 9, 20'h49, 32'h4949_4949, 0);
    send(5, 1, 0, 0, 0, 0, 20'h0, 64'h19, "R9", 0);
    send(0, 1, 0, 0, 0, 1, 20'h0, 64'h1A, "R9", 0);
    // R14 saturation and touch on invalid entry
    fill(1, 9, 20'h49, 32'h9999_0000, 0);
    touch(1, 9, 300);
    touch(1, 10, 4);
    send(0, 1, 1, 0, 0, 9, 20'h0, 64'h1B, "R14", 0);
    send(0, 1, 0, 0, 0, 10, 20'h0, 64'h1C, "R14", 0);

    repeat (5) @(negedge clk);
    check(q.size() == 0, "R2", "statuses outstanding", 64'(q.size()), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule